// File: doc/BRIEF.md
# Multi-Format Unsigned Divide Unit

A sequential unsigned integer divider for a processor execute stage. The caller presents a form selector, a destination operand `dq_i`, a second data register `dr_i` (high dividend half in the 64-bit form) and a divisor. A pulse on `start_i` while idle starts the operation. The unit returns the values to write back to the quotient and remainder registers, one write enable for each, processor-style N/Z/V/C flags and a divide-by-zero trap request. All of these are valid only in the single cycle in which `done_o` is high.

Four forms are supported. The 16-bit form divides a 32-bit dividend by a 16-bit divisor and packs the remainder above the quotient in one register. The quotient-only 32-bit form discards the remainder. The 64/32 form takes its dividend from two registers. The 32-bit remainder form writes both registers. A zero divisor and an oversized quotient are both detected at start and end the operation one cycle later with no register write. Otherwise a restoring shift-subtract loop produces one quotient bit per clock.

Top module: `divu_unit`

## Requirements
- R1: Form 2'b00 (16-bit): the divisor is `divisor_i[15:0]`. `dq_wdata_o` = {remainder[15:0], quotient[15:0]} of `dq_i` / divisor, with `dq_we_o`=1 and `dr_we_o`=0.
- R2: Form 2'b01 (32/32, quotient only): `dq_wdata_o` = `dq_i` / `divisor_i` with `dq_we_o`=1. `dr_we_o`=0.
- R3: Form 2'b10 (64/32): the dividend is {`dr_i`, `dq_i`}. `dq_wdata_o` is the 32-bit quotient and `dr_wdata_o` is the 32-bit remainder, and both enables are 1.
- R4: Form 2'b11 (32/32 with remainder): `dq_wdata_o` = `dq_i` / `divisor_i` and `dr_wdata_o` = `dq_i` % `divisor_i`, and both enables are 1.
- R5: A zero divisor (`divisor_i[15:0]` in form 2'b00, all 32 bits otherwise) raises `dz_trap_o` with `done_o`. Both enables are 0 and N, Z, V and C are 0.
- R6: Overflow raises `flag_v_o` with both enables 0 and N=Z=0. In form 2'b00 it occurs when `dq_i[31:16]` >= divisor; in form 2'b10 it occurs when `dr_i` >= `divisor_i`. The other forms never overflow. A zero divisor takes precedence.
- R7: On a completed division, N is the MSB of the quotient field (bit 15 in form 2'b00, bit 31 otherwise) and Z is 1 when that field is zero. V=0, and `flag_c_o` is 0 at all times.
- R8: `done_o` is high for exactly one cycle. It rises 17 clock edges after the accepting edge in form 2'b00, 33 edges after it in the other forms, and 1 edge after it on a trap or an overflow.
- R9: `busy_o` is high from the accepting edge through the `done_o` cycle. A `start_i` seen while `busy_o` is high is ignored.
- R10: When `same_reg_i`=1 in form 2'b10 or 2'b11, `dr_we_o`=0, so the quotient write alone reaches the shared register.
- R11: During reset and after it, `busy_o`, `done_o`, both enables and `dz_trap_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| form_i | input | 2 | Form selector (00 16-bit, 01 quotient only, 10 64/32, 11 32/32 with remainder) |
| same_reg_i | input | 1 | The quotient and remainder registers are the same register |
| dq_i | input | 32 | Destination operand / low dividend |
| dr_i | input | 32 | High dividend in form 10 |
| divisor_i | input | 32 | Divisor; only the low 16 bits are used in form 00 |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| dq_wdata_o | output | 32 | Write-back value for the quotient register |
| dq_we_o | output | 1 | Write enable for the quotient register |
| dr_wdata_o | output | 32 | Write-back value for the remainder register |
| dr_we_o | output | 1 | Write enable for the remainder register |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, always 0 |
| dz_trap_o | output | 1 | Divide-by-zero trap request |

## Verification
The bench aims at the overflow boundary: a high part exactly equal to the divisor must abort, and a high part one below it must divide. A design that compares with > instead of >= would write a truncated quotient instead of setting V. In the 16-bit form the bench uses a divisor whose low half is zero and whose high half is not. A unit that tested all 32 bits would divide instead of trapping. It also checks quotient-field MSBs for N, shared-register writes with no remainder enable, and a start pulse during a run. Wrong N bit selection, a double write, or a restarted loop each show up as a mismatch against the per-cycle model.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic [1:0] {
    FORM_W16   = 2'b00,
    FORM_L32Q  = 2'b01,
    FORM_L64   = 2'b10,
    FORM_L32QR = 2'b11
  } divu_form_e;
endpackage

// File: rtl/divu_precheck.sv
module divu_precheck
  import divu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  divu_form_e        form_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              div_zero_o,
  output logic              ovf_o,
  output logic [DATA_W-1:0] rem_init_o,
  output logic [DATA_W-1:0] quo_init_o,
  output logic [DATA_W-1:0] div_eff_o,
  output logic [CNT_W-1:0]  iters_o
);
  always_comb begin
    unique case (form_i)
      FORM_W16: begin
        div_eff_o  = {{HALF_W{1'b0}}, divisor_i[HALF_W-1:0]};
        rem_init_o = {{HALF_W{1'b0}}, dq_i[DATA_W-1:HALF_W]};
        quo_init_o = {dq_i[HALF_W-1:0], {HALF_W{1'b0}}};
        iters_o    = CNT_W'(HALF_W);
        ovf_o      = dq_i[DATA_W-1:HALF_W] >= divisor_i[HALF_W-1:0];
      end
      FORM_L64: begin
        div_eff_o  = divisor_i;
        rem_init_o = dr_i;
        quo_init_o = dq_i;
        iters_o    = CNT_W'(DATA_W);
        ovf_o      = dr_i >= divisor_i;
      end
      default: begin
        div_eff_o  = divisor_i;
        rem_init_o = '0;
        quo_init_o = dq_i;
        iters_o    = CNT_W'(DATA_W);
        ovf_o      = 1'b0;
      end
    endcase
    div_zero_o = div_eff_o == '0;
  end
endmodule

// File: rtl/divu_core.sv
module divu_core #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rem_init_i,
  input  logic [DATA_W-1:0] quo_init_i,
  input  logic [DATA_W-1:0] div_i,
  input  logic [CNT_W-1:0]  iters_i,
  output logic              run_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o
);
  logic              run_q, fin_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rem_q, quo_q, div_q;
  logic [DATA_W:0]   shifted, diff;
  logic              q_bit;

  // restoring step: partial remainder stays below the divisor
  always_comb begin
    shifted = {rem_q, quo_q[DATA_W-1]};
    diff    = shifted - {1'b0, div_q};
    q_bit   = ~diff[DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fin_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      fin_q <= 1'b0;
      cnt_q <= iters_i;
      rem_q <= rem_init_i;
      quo_q <= quo_init_i;
      div_q <= div_i;
    end else if (run_q) begin
      rem_q <= q_bit ? diff[DATA_W-1:0] : shifted[DATA_W-1:0];
      quo_q <= {quo_q[DATA_W-2:0], q_bit};
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign run_o = run_q;
  assign fin_o = fin_q;
  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> rem_q < div_q);  // R3
  AST_FIN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |=> !fin_q);  // R8
endmodule

// File: rtl/divu_pack.sv
module divu_pack
  import divu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  divu_form_e        form_i,
  input  logic              same_reg_i,
  input  logic              res_valid_i,
  input  logic              abort_valid_i,
  input  logic              trap_i,
  input  logic              ovf_i,
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] rem_i,
  output logic [DATA_W-1:0] dq_wdata_o,
  output logic              dq_we_o,
  output logic [DATA_W-1:0] dr_wdata_o,
  output logic              dr_we_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              dz_trap_o
);
  logic is_word, has_rem;

  always_comb begin
    is_word    = form_i == FORM_W16;
    has_rem    = (form_i == FORM_L64) || (form_i == FORM_L32QR);
    dq_wdata_o = is_word ? {rem_i[HALF_W-1:0], quo_i[HALF_W-1:0]} : quo_i;
    dr_wdata_o = rem_i;
    dq_we_o    = res_valid_i;
    // shared register: quotient wins
    dr_we_o    = res_valid_i && has_rem && !same_reg_i;
    flag_n_o   = res_valid_i && (is_word ? quo_i[HALF_W-1] : quo_i[DATA_W-1]);
    flag_z_o   = res_valid_i && (is_word ? (quo_i[HALF_W-1:0] == '0) : (quo_i == '0));
    flag_v_o   = abort_valid_i && ovf_i && !trap_i;
    flag_c_o   = 1'b0;
    dz_trap_o  = abort_valid_i && trap_i;
  end
endmodule

// File: rtl/divu_unit.sv
module divu_unit
  import divu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        form_i,
  input  logic              same_reg_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] dq_wdata_o,
  output logic              dq_we_o,
  output logic [DATA_W-1:0] dr_wdata_o,
  output logic              dr_we_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              dz_trap_o
);
  divu_form_e        form_in, form_q;
  logic              same_q, trap_q, ovf_q, abort_q;
  logic              div_zero, ovf, accept, load;
  logic              core_run, core_fin;
  logic [DATA_W-1:0] rem_init, quo_init, div_eff, quo, rem;
  logic [CNT_W-1:0]  iters;

  assign form_in = divu_form_e'(form_i);

  divu_precheck #(.DATA_W(DATA_W)) u_chk (
    .form_i(form_in), .dq_i(dq_i), .dr_i(dr_i), .divisor_i(divisor_i),
    .div_zero_o(div_zero), .ovf_o(ovf), .rem_init_o(rem_init),
    .quo_init_o(quo_init), .div_eff_o(div_eff), .iters_o(iters)
  );

  assign busy_o = core_run | core_fin | abort_q;
  assign accept = start_i && !busy_o;
  assign load   = accept && !div_zero && !ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      form_q  <= FORM_W16;
      same_q  <= 1'b0;
      trap_q  <= 1'b0;
      ovf_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= accept && (div_zero || ovf);
      if (accept) begin
        form_q <= form_in;
        same_q <= same_reg_i;
        trap_q <= div_zero;
        ovf_q  <= ovf;
      end
    end
  end

  divu_core #(.DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .rem_init_i(rem_init), .quo_init_i(quo_init), .div_i(div_eff),
    .iters_i(iters), .run_o(core_run), .fin_o(core_fin),
    .quo_o(quo), .rem_o(rem)
  );

  assign done_o = core_fin | abort_q;

  divu_pack #(.DATA_W(DATA_W)) u_pack (
    .form_i(form_q), .same_reg_i(same_q), .res_valid_i(core_fin),
    .abort_valid_i(abort_q), .trap_i(trap_q), .ovf_i(ovf_q),
    .quo_i(quo), .rem_i(rem),
    .dq_wdata_o(dq_wdata_o), .dq_we_o(dq_we_o),
    .dr_wdata_o(dr_wdata_o), .dr_we_o(dr_we_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_v_o(flag_v_o),
    .flag_c_o(flag_c_o), .dz_trap_o(dz_trap_o)
  );

  AST_ZERO_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && div_zero |=> dz_trap_o && done_o);  // R5
  AST_TRAP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_trap_o |-> !dq_we_o && !dr_we_o && !flag_v_o);  // R5
  AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_v_o |-> !dq_we_o && !dr_we_o && !flag_n_o && !flag_z_o);  // R6
  AST_OVF_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ovf && !div_zero |=> flag_v_o && done_o);  // R6
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);  // R9
  AST_SHARED_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && same_reg_i |=> !dr_we_o);  // R10
endmodule

// File: tb/sim_divu_unit.sv
module sim_divu_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  form_i = 2'b00;
  logic        same_reg_i = 1'b0;
  logic [31:0] dq_i = '0, dr_i = '0, divisor_i = '0;
  logic        busy_o, done_o, dq_we_o, dr_we_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, dz_trap_o;
  logic [31:0] dq_wdata_o, dr_wdata_o;

  int n_tests = 0, n_fail = 0;
  string cur_tag = "R11";

  always #5 clk_i = ~clk_i;

  divu_unit u0 (.*);

  // reference model state
  int          m_cnt = 0;
  string       e_tag;
  logic [31:0] e_dq, e_dr;
  logic        e_dqwe, e_drwe, e_n, e_z, e_v, e_trap;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_start();
    logic [31:0] dv;
    logic [63:0] dd, q, r;
    dv = (form_i == 2'b00) ? {16'h0, divisor_i[15:0]} : divisor_i;
    e_tag = cur_tag;
    {e_dqwe, e_drwe, e_n, e_z, e_v, e_trap} = '0;
    e_dq = '0; e_dr = '0;
    if (dv == 0) begin
      e_trap = 1'b1; m_cnt = 1;
    end else if ((form_i == 2'b00 && dq_i[31:16] >= dv) ||
                 (form_i == 2'b10 && dr_i >= dv)) begin
      e_v = 1'b1; m_cnt = 1;
    end else begin
      dd = (form_i == 2'b10) ? {dr_i, dq_i} : {32'h0, dq_i};
      q = dd / {32'h0, dv};
      r = dd % {32'h0, dv};
      e_dqwe = 1'b1;
      e_dr = r[31:0];
      if (form_i == 2'b00) begin
        e_dq = {r[15:0], q[15:0]};
        e_n = q[15]; e_z = q[15:0] == 0;
        m_cnt = 17;
      end else begin
        e_dq = q[31:0];
        e_n = q[31]; e_z = q[31:0] == 0;
        e_drwe = form_i[1] && !same_reg_i;
        m_cnt = 33;
      end
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_cnt = 0;
    else if (m_cnt > 0) m_cnt--;
    else if (start_i) model_start();
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      chk(!busy_o && !done_o && !dq_we_o && !dr_we_o && !dz_trap_o, "R11",
          "reset outputs", {busy_o, done_o, dq_we_o, dr_we_o, dz_trap_o}, 0);
    end else begin
      chk(busy_o == (m_cnt > 0), "R9", "busy", busy_o, m_cnt > 0);
      chk(done_o == (m_cnt == 1), "R8", "done", done_o, m_cnt == 1);
      chk(flag_c_o == 1'b0, "R7", "C", flag_c_o, 0);
      if (m_cnt == 1) begin
        chk(dz_trap_o == e_trap, e_tag, "trap", dz_trap_o, e_trap);
        chk(flag_v_o == e_v, e_tag, "V", flag_v_o, e_v);
        chk(flag_n_o == e_n, e_tag, "N", flag_n_o, e_n);
        chk(flag_z_o == e_z, e_tag, "Z", flag_z_o, e_z);
        chk(dq_we_o == e_dqwe, e_tag, "dq_we", dq_we_o, e_dqwe);
        chk(dr_we_o == e_drwe, e_tag, "dr_we", dr_we_o, e_drwe);
        if (e_dqwe) chk(dq_wdata_o == e_dq, e_tag, "dq_wdata", dq_wdata_o, e_dq);
        if (e_drwe) chk(dr_wdata_o == e_dr, e_tag, "dr_wdata", dr_wdata_o, e_dr);
      end else begin
        chk(!dq_we_o && !dr_we_o && !dz_trap_o && !flag_v_o, "R8",
            "idle outputs", {dq_we_o, dr_we_o, dz_trap_o, flag_v_o}, 0);
      end
    end
  end

  task automatic run_op(input logic [1:0] f, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] d, input bit same, input string tag,
                        input bit poke = 0);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    cur_tag = tag;
    form_i = f; dq_i = a; dr_i = b; divisor_i = d; same_reg_i = same;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R9: start during a run must be ignored
      repeat (3) @(negedge clk_i);
      form_i = 2'b01; dq_i = 32'h1234_5678; divisor_i = 32'h0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk_i);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        run_op(2'b00, 32'h0001_2345, 0, 32'h0000_0100, 0, "R1");
        run_op(2'b00, 32'h0004_FFFF, 0, 32'h0000_0005, 0, "R7");  // N from bit 15, just below overflow
        run_op(2'b00, 32'h0000_0003, 0, 32'hFFFF_0007, 0, "R1");  // Z, upper divisor bits ignored
        run_op(2'b00, 32'h0005_0000, 0, 32'h0000_0005, 0, "R6");  // equal -> overflow
        run_op(2'b00, 32'h0005_0000, 0, 32'h0001_0000, 0, "R5");  // low half zero -> trap
        run_op(2'b01, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h0000_0003, 0, "R2");
        run_op(2'b01, 32'h0000_0004, 0, 32'h0000_0009, 0, "R2");  // quotient zero
        run_op(2'b01, 32'h8000_0001, 0, 32'h0000_0001, 0, "R7");  // N from bit 31
        run_op(2'b10, 32'h0000_0000, 32'h0000_0001, 32'h0000_0003, 0, "R3");
        run_op(2'b10, 32'h1234_5678, 32'h7FFF_FFFE, 32'h7FFF_FFFF, 0, "R3");
        run_op(2'b10, 32'h0, 32'h0000_0007, 32'h0000_0007, 0, "R6");  // equal -> overflow
        run_op(2'b10, 32'h1, 32'h0000_0007, 32'h0, 0, "R5");  // zero beats overflow
        run_op(2'b11, 32'hDEAD_BEEF, 32'h0, 32'h0000_1001, 0, "R4");
        run_op(2'b11, 32'hDEAD_BEEF, 32'h0, 32'h0000_1001, 1, "R10");
        run_op(2'b10, 32'h0, 32'h0000_0002, 32'h0000_0005, 1, "R10");
        run_op(2'b11, 32'h0000_0000, 32'h0, 32'h0, 0, "R5");
        run_op(2'b11, 32'h0009_8765, 32'h0, 32'h0000_0077, 0, "R9", 1);
        run_op(2'b00, 32'h0000_1234, 0, 32'h0000_0010, 0, "R9", 1);
        begin
          logic [31:0] s = 32'h1357_9BDF;
          for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b, d;
            s = s * 32'd1664525 + 32'd1013904223; a = s;
            s = s * 32'd1664525 + 32'd1013904223; b = s >> (i % 8);
            s = s * 32'd1664525 + 32'd1013904223; d = s >> (i % 24);
            run_op(2'(i), a, b, d, i[2], "R8");
          end
        end
        repeat (3) @(negedge clk_i);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule